// File: doc/BRIEF.md
# Three-Wire Serial Register Bank

This block receives configuration words over a three-wire serial link (clock, data, latch) and keeps them in six 24-bit control registers. Bits enter a 24-bit shift register most significant bit first. A rising edge on the latch line copies the shift contents into the register whose address code sits in the low bits of the word. The serial clock and latch lines are asynchronous to the system clock. Each is passed through a two-stage synchronizer and then an edge detector.

The bank also drives decoded controls. The effective band merges a band pin with a band bit. The power enable merges a chip-enable pin with a power-down bit. A default-select bit makes the three upper registers read as fixed defaults, and while that bit is set it also blocks writes to them.

Top module: `ser_cfg_bank`

## Requirements
- R1: Each rising edge of `ser_clk` shifts `ser_data` into the low end of a 24-bit shift register, so after 24 edges the first bit sent is bit 23.
- R2: On a rising edge of `ser_le`, the shift contents load into the register selected by the low address bits. The codes are: bits[1:0]=00 selects word 0, bits[1:0]=01 selects word 1, bits[1:0]=10 selects word 2, bits[2:0]=011 selects word 3, bits[3:0]=0111 selects word 4, and bits[4:0]=01111 selects word 5.
- R3: A word whose bits[4:0] are 11111 is discarded, and no register changes.
- R4: After reset the registers hold their default words. Word 0 is 24'h040000 and word 1 is 24'h800071. The defaults of words 2 to 5 are 24'hC00002, 24'h5A0003, 24'h0C4007 and 24'h12300F.
- R5: While word 1 bit 23 (`dflt_sel_o`) is 1, writes to words 3 to 5 are ignored and `cfg3_o` to `cfg5_o` show the defaults. While that bit is 0, those outputs show the stored words.
- R6: Word 0 fields are: bit 23 `rxtx_o`, bit 22 power-down bit, bit 21 `fast_lock_o`, bit 19 band bit, bits 18:15 `div_b_o`, bits 14:12 `div_a_o`, and bits 11:2 `frac_o`.
- R7: Word 1 fields are: bit 6 `lock_en_o`, bits 5:4 `buf_lvl_o`, and bits 3:2 `ref_sel_o`. `cfg2_o` is the whole of word 2.
- R8: `pwr_on_o` is 1 only when `chip_en` is 1 and the power-down bit is 0. Register writes still take effect while `chip_en` is 0.
- R9: `band_hi_o` is 1 when `band_pin` is 1 or the band bit is 1. With the pin at 0 and the bit at 0 it is 0.
- R10: Shifting without a latch rising edge changes no register. A later latch edge alone loads the word already in the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data |
| ser_le | input | 1 | Serial latch |
| chip_en | input | 1 | Chip-enable pin |
| band_pin | input | 1 | Band-select pin |
| pwr_on_o | output | 1 | Effective power enable |
| band_hi_o | output | 1 | Effective band, 1 = high band |
| rxtx_o | output | 1 | Receive/transmit bit |
| fast_lock_o | output | 1 | Fast lock mode bit |
| div_b_o | output | 4 | Programmable counter value |
| div_a_o | output | 3 | Swallow counter value |
| frac_o | output | 10 | Fractional numerator |
| dflt_sel_o | output | 1 | Default-select bit |
| lock_en_o | output | 1 | Lock indicator enable |
| buf_lvl_o | output | 2 | Output buffer level |
| ref_sel_o | output | 2 | Reference frequency select |
| cfg2_o | output | 24 | Word 2 |
| cfg3_o | output | 24 | Effective word 3 |
| cfg4_o | output | 24 | Effective word 4 |
| cfg5_o | output | 24 | Effective word 5 |

## Verification
The assertions check three things on every cycle. The shift register holds still without a serial clock edge. No register moves without a latch edge. An address of 11111, or an upper-register write while defaults are selected, leaves the bank untouched. Only the bench's serial scenarios can show the following: the bit order, the field positions, the full truth tables for band and power, and that a stored word reappears when the default-select bit is cleared.

// File: rtl/ser_cfg_bank.sv
module ser_cfg_bank #(
  parameter int          SYNC = 2,
  parameter logic [23:0] DEF0 = 24'h040000,
  parameter logic [23:0] DEF1 = 24'h800071,
  parameter logic [23:0] DEF2 = 24'hC00002,
  parameter logic [23:0] DEF3 = 24'h5A0003,
  parameter logic [23:0] DEF4 = 24'h0C4007,
  parameter logic [23:0] DEF5 = 24'h12300F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_clk,
  input  logic        ser_data,
  input  logic        ser_le,
  input  logic        chip_en,
  input  logic        band_pin,
  output logic        pwr_on_o,
  output logic        band_hi_o,
  output logic        rxtx_o,
  output logic        fast_lock_o,
  output logic [3:0]  div_b_o,
  output logic [2:0]  div_a_o,
  output logic [9:0]  frac_o,
  output logic        dflt_sel_o,
  output logic        lock_en_o,
  output logic [1:0]  buf_lvl_o,
  output logic [1:0]  ref_sel_o,
  output logic [23:0] cfg2_o,
  output logic [23:0] cfg3_o,
  output logic [23:0] cfg4_o,
  output logic [23:0] cfg5_o
);
  logic [SYNC:0] ck_s, le_s, dt_s;
  logic [23:0]   sh, w0, w1, w2, w3, w4, w5;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ck_s <= '0; le_s <= '0; dt_s <= '0;
    end else begin
      ck_s <= {ck_s[SYNC-1:0], ser_clk};
      le_s <= {le_s[SYNC-1:0], ser_le};
      dt_s <= {dt_s[SYNC-1:0], ser_data};
    end

  wire sclk_rise = ck_s[SYNC-1] & ~ck_s[SYNC];
  wire le_rise   = le_s[SYNC-1] & ~le_s[SYNC];
  wire upper_ok  = ~w1[23];
  wire sel0 = sh[1:0] == 2'b00;
  wire sel1 = sh[1:0] == 2'b01;
  wire sel2 = sh[1:0] == 2'b10;
  wire sel3 = sh[2:0] == 3'b011;
  wire sel4 = sh[3:0] == 4'b0111;
  wire sel5 = sh[4:0] == 5'b01111;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sh <= '0;
    else if (sclk_rise) sh <= {sh[22:0], dt_s[SYNC-1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      w0 <= DEF0; w1 <= DEF1; w2 <= DEF2;
      w3 <= DEF3; w4 <= DEF4; w5 <= DEF5;
    end else if (le_rise) begin
      if (sel0) w0 <= sh;
      if (sel1) w1 <= sh;
      if (sel2) w2 <= sh;
      if (sel3 && upper_ok) w3 <= sh;
      if (sel4 && upper_ok) w4 <= sh;
      if (sel5 && upper_ok) w5 <= sh;
    end

  assign pwr_on_o    = chip_en & ~w0[22];
  assign band_hi_o   = band_pin | w0[19];
  assign rxtx_o      = w0[23];
  assign fast_lock_o = w0[21];
  assign div_b_o     = w0[18:15];
  assign div_a_o     = w0[14:12];
  assign frac_o      = w0[11:2];
  assign dflt_sel_o  = w1[23];
  assign lock_en_o   = w1[6];
  assign buf_lvl_o   = w1[5:4];
  assign ref_sel_o   = w1[3:2];
  assign cfg2_o      = w2;
  assign cfg3_o      = w1[23] ? DEF3 : w3;
  assign cfg4_o      = w1[23] ? DEF4 : w4;
  assign cfg5_o      = w1[23] ? DEF5 : w5;

  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_rise |=> $stable(sh)); // R1
  AST_NO_LATCH_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !le_rise |=> $stable({w0, w1, w2, w3, w4, w5})); // R10
  AST_BAD_ADDR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && sh[4:0] == 5'b11111) |=> $stable({w0, w1, w2, w3, w4, w5})); // R3
  AST_UPPER_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && w1[23] && sh[1:0] == 2'b11) |=> $stable({w3, w4, w5})); // R5
  AST_WORD0_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && sh[1:0] == 2'b00) |=> w0 == $past(sh)); // R2
endmodule

// File: tb/ser_cfg_bank_tb.sv
`timescale 1ns/1ps
module ser_cfg_bank_tb_top;
  logic clk = 0, rst_n = 0, ser_clk = 0, ser_data = 0, ser_le = 0, chip_en = 1, band_pin = 0;
  logic pwr_on_o, band_hi_o, rxtx_o, fast_lock_o, dflt_sel_o, lock_en_o;
  logic [3:0] div_b_o; logic [2:0] div_a_o; logic [9:0] frac_o;
  logic [1:0] buf_lvl_o, ref_sel_o;
  logic [23:0] cfg2_o, cfg3_o, cfg4_o, cfg5_o;
  int n_chk = 0, n_fail = 0;
  logic [23:0] e0, e1, e2, e3, e4, e5;
  localparam logic [23:0] D3 = 24'h5A0003, D4 = 24'h0C4007, D5 = 24'h12300F;

  always #2.5 clk = ~clk;

  ser_cfg_bank dut_i (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_word(logic [23:0] w);
    for (int i = 23; i >= 0; i--) begin
      ser_data = w[i]; ser_clk = 0; wait_clk(4);
      ser_clk = 1; wait_clk(4);
    end
    ser_clk = 0; wait_clk(4);
  endtask

  task automatic latch();
    ser_le = 1; wait_clk(4); ser_le = 0; wait_clk(6);
  endtask

  function automatic void model(logic [23:0] w);
    if (w[1:0] == 2'b00) e0 = w;
    else if (w[1:0] == 2'b01) e1 = w;
    else if (w[1:0] == 2'b10) e2 = w;
    else if (!e1[23]) begin
      if (w[2:0] == 3'b011) e3 = w;
      else if (w[3:0] == 4'b0111) e4 = w;
      else if (w[4:0] == 5'b01111) e5 = w;
    end
  endfunction

  task automatic send(logic [23:0] w);
    shift_word(w); latch(); model(w);
  endtask

  task automatic check_all(string tag);
    chk({tag, " R6 word0 fields"}, {rxtx_o, fast_lock_o, div_b_o, div_a_o, frac_o},
        {e0[23], e0[21], e0[18:15], e0[14:12], e0[11:2]});
    chk({tag, " R7 word1 fields"}, {dflt_sel_o, lock_en_o, buf_lvl_o, ref_sel_o},
        {e1[23], e1[6], e1[5:4], e1[3:2]});
    chk({tag, " R7 word2"}, cfg2_o, e2);
    chk({tag, " R5 word3"}, cfg3_o, e1[23] ? D3 : e3);
    chk({tag, " R5 word4"}, cfg4_o, e1[23] ? D4 : e4);
    chk({tag, " R5 word5"}, cfg5_o, e1[23] ? D5 : e5);
  endtask

  initial begin
    e0 = 24'h040000; e1 = 24'h800071; e2 = 24'hC00002;
    e3 = D3; e4 = D4; e5 = D5;
    wait_clk(3); rst_n = 1; wait_clk(2);
    check_all("R4 reset");
    chk("R8 reset power", pwr_on_o, 1);
    chk("R9 reset band", band_hi_o, 0);

    for (int k = 0; k < 6; k++) begin
      logic [23:0] w = (24'hA5C3F0 ^ (24'h13579B * k)) & 24'hFFFFFC;
      send(w);
      check_all("R2 R1 word0 sweep");
    end
    send(24'h9ABCD1); check_all("R2 word1");
    send(24'h3F0F0E); check_all("R2 word2");

    send(24'hDEAD03); send(24'hBEEF07); send(24'hCAFE0F);
    check_all("R5 locked writes");
    send(24'h000071);
    send(24'hDEAD03); send(24'hBEEF07); send(24'hCAFE0F);
    check_all("R5 unlocked writes");
    chk("R2 word3 code 011", cfg3_o, 24'hDEAD03);
    chk("R2 word5 code 01111", cfg5_o, 24'hCAFE0F);
    send(24'h800071); check_all("R5 defaults back");
    send(24'h000071); check_all("R5 stored words return");

    send(24'hFFFFFF); check_all("R3 discard 11111");
    send(24'h12341F); check_all("R3 discard 11111 second");

    shift_word(24'h7FFFF0);
    check_all("R10 shift without latch");
    latch(); model(24'h7FFFF0);
    check_all("R10 latch alone loads");

    for (int c = 0; c < 2; c++)
      for (int pd = 0; pd < 2; pd++) begin
        chip_en = c[0];
        if (c == 0) begin send({1'b0, pd[0], 22'h01F0A0}); end
        else send({1'b0, pd[0], 22'h02A550});
        wait_clk(1);
        chk("R8 power merge", pwr_on_o, c[0] & ~pd[0]);
        check_all("R8 write while chip_en state");
      end
    chip_en = 1;

    for (int b = 0; b < 2; b++) begin
      send({4'h0, b[0], 19'h2C44C});
      for (int p = 0; p < 2; p++) begin
        band_pin = p[0]; wait_clk(1);
        chk("R9 band merge", band_hi_o, p[0] | b[0]);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule